// File: doc/BRIEF.md
# GPIO Input Port with Masked Pin Configuration

This block is an eight-pin general-purpose input port controlled through a small register bus. Every pin passes through a two-flop synchronizer. The synchronized value can be read in an input register, and it also feeds a per-pin sense stage. Each pin has its own three-bit control register. That register picks the sense mode: both edges, rising edge, falling edge, low level, or input off. Each sense stage drives a one-cycle event output and sets a sticky interrupt flag. The enabled flags are ORed into a single registered interrupt request.

A separate mask register lets software configure several pins with one bus write. Software loads the mask first and then writes any one pin-control register. The value written lands in the addressed pin and in every pin whose mask bit is set. The mask then clears itself, so the next control write affects one pin only.

Bus writes take effect on the clock edge where `bus_we` is high. Read data is registered and appears one cycle after the address. Reset is synchronous and active high.

Top module: `gpio_mp_port`

## Requirements
- R1: After reset the mask, interrupt enable, flag and pin-control registers read zero, and `irq`, `pin_event` and `bus_rdata` are zero.
- R2: The input register at address 0x00 returns the pins after a two-flop synchronizer. `bus_rdata` is registered, so a pin change becomes readable on the third rising edge after the change.
- R3: A write to the pin-control register of pin n (address 0x08+n, sense code in data bits [2:0]) updates pin n and every pin whose mask bit is set, including when mask bit n is clear. Bits [7:3] of a pin-control register read as zero.
- R4: The mask register (address 0x01, bit n selects pin n) reads zero after any pin-control write.
- R5: Sense code 001 (rising) raises `pin_event[n]` for exactly one cycle, three rising edges after a 0-to-1 pin change, and sets flag n. A 1-to-0 change produces nothing.
- R6: Sense code 010 (falling) gives the same one-cycle event and flag on a 1-to-0 change, and nothing on a 0-to-1 change.
- R7: Sense code 000 (both edges) gives an event and sets the flag on every change.
- R8: Sense code 011 (low level) keeps flag n set while the synchronized pin is low, even while software writes one to clear it. `pin_event[n]` is low while the pin is low and high on every cycle while the pin is high.
- R9: Sense code 111 (input off) forces the pin's bit in the input register to zero and suppresses its events and flag.
- R10: Sense codes 100, 101 and 110 read back as written and produce no events or flags, while the input register still reports the pin.
- R11: The flag register (address 0x03) is write-one-to-clear. A written zero bit leaves its flag unchanged.
- R12: `irq` goes high one cycle after any flag whose enable bit (address 0x02) is set becomes set. Flags on pins that are not enabled leave `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_event | output | 8 | Registered per-pin event |
| irq | output | 1 | Registered port interrupt request |

## Verification
The assertions assume that `bus_we` asserts for a single address per cycle. They also assume that a pin's sense mode is not rewritten in the same window in which that pin's edge is being detected. The mode checks relate the mode present on one edge to the event on the next, so a mode change would make those relations ambiguous. The stimulus respects this by changing configuration only while all pins are stable. It then moves one pin at a time, holding each pin level for several cycles.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

  localparam int SENSE_W = 3;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_BOTH = 3'b000,
    SENSE_RISE = 3'b001,
    SENSE_FALL = 3'b010,
    SENSE_LOW  = 3'b011,
    SENSE_RSV4 = 3'b100,
    SENSE_RSV5 = 3'b101,
    SENSE_RSV6 = 3'b110,
    SENSE_OFF  = 3'b111
  } sense_e;

  // register addresses
  localparam int REG_IN        = 0;
  localparam int REG_MASK      = 1;
  localparam int REG_INTEN     = 2;
  localparam int REG_FLAGS     = 3;
  localparam int REG_CTRL_BASE = 8;

endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_mp_sense.sv
module gpio_mp_sense
  import gpio_mp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_i,
  input  logic [SENSE_W-1:0] mode_i,
  output logic               pin_val_o,
  output logic               hit_o,
  output logic               evt_o
);

  logic hist_q;
  logic evt_q;
  logic eff;
  logic rise;
  logic fall;
  logic evt_c;
  logic hit_c;

  // the off code blanks the pin for both reading and sensing
  assign eff  = (mode_i == SENSE_OFF) ? 1'b0 : sync_i;
  assign rise = eff & ~hist_q;
  assign fall = ~eff & hist_q;

  always_comb begin
    evt_c = 1'b0;
    hit_c = 1'b0;
    case (mode_i)
      SENSE_BOTH: begin evt_c = rise | fall; hit_c = rise | fall; end
      SENSE_RISE: begin evt_c = rise;        hit_c = rise;        end
      SENSE_FALL: begin evt_c = fall;        hit_c = fall;        end
      SENSE_LOW:  begin evt_c = eff;         hit_c = ~eff;        end
      default:    begin evt_c = 1'b0;        hit_c = 1'b0;        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      hist_q <= eff;
      evt_q  <= evt_c;
    end
  end

  assign pin_val_o = eff;
  assign hit_o     = hit_c;
  assign evt_o     = evt_q;

  a_r5_rise_fires: assert property (@(posedge clk) disable iff (rst)
    (mode_i == SENSE_RISE && sync_i && !hist_q) |=> evt_q)
    else $error("R5 rising edge without event");

  a_r6_fall_ignores_rise: assert property (@(posedge clk) disable iff (rst)
    (mode_i == SENSE_FALL && sync_i && !hist_q) |=> !evt_q)
    else $error("R6 falling mode reacted to rise");

  a_r9_off_silent: assert property (@(posedge clk) disable iff (rst)
    (mode_i == SENSE_OFF) |=> !evt_q)
    else $error("R9 event from disabled pin");

  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (mode_i[2] && mode_i != SENSE_OFF) |=> !evt_q)
    else $error("R10 event from reserved code");

endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
  import gpio_mp_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic                               we_i,
  input  logic [NUM_PINS-1:0]                in_val_i,
  input  logic [NUM_PINS-1:0]                hit_i,
  output logic [NUM_PINS-1:0][SENSE_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0]                  rdata_o,
  output logic                               irq_o
);

  localparam logic [ADDR_W-1:0] A_IN       = ADDR_W'(REG_IN);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(REG_MASK);
  localparam logic [ADDR_W-1:0] A_INTEN    = ADDR_W'(REG_INTEN);
  localparam logic [ADDR_W-1:0] A_FLAGS    = ADDR_W'(REG_FLAGS);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(REG_CTRL_BASE);
  localparam logic [ADDR_W-1:0] A_CTRL_END = ADDR_W'(REG_CTRL_BASE + NUM_PINS);

  logic [NUM_PINS-1:0][SENSE_W-1:0] ctrl_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] inten_q;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] clr;
  logic [DATA_W-1:0]   rdata_q;
  logic [DATA_W-1:0]   rd_c;
  logic [ADDR_W-1:0]   ctrl_off;
  logic                in_ctrl;
  logic                ctrl_wr;
  logic                irq_q;

  assign ctrl_off = addr_i - A_CTRL;
  assign in_ctrl  = (addr_i >= A_CTRL) && (addr_i < A_CTRL_END);
  assign ctrl_wr  = we_i && in_ctrl;
  assign clr      = (we_i && addr_i == A_FLAGS) ? wdata_i[NUM_PINS-1:0] : '0;

  // one control write fans out to the addressed pin and the masked pins
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_q[i] <= '0;
      else if (ctrl_wr && (mask_q[i] || ctrl_off == ADDR_W'(i)))
        ctrl_q[i] <= wdata_i[SENSE_W-1:0];
    end

    a_r3_broadcast: assert property (@(posedge clk) disable iff (rst)
      (ctrl_wr && mask_q[i]) |=> (ctrl_q[i] == $past(wdata_i[SENSE_W-1:0])))
      else $error("R3 masked pin missed broadcast");

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr[i]) |=> flag_q[i])
      else $error("R11 flag dropped without clear");

    a_r11_flag_clears: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !hit_i[i]) |=> !flag_q[i])
      else $error("R11 flag survived clear");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      inten_q <= '0;
      flag_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr)
        mask_q <= '0;
      else if (we_i && addr_i == A_MASK)
        mask_q <= wdata_i[NUM_PINS-1:0];
      if (we_i && addr_i == A_INTEN)
        inten_q <= wdata_i[NUM_PINS-1:0];
      flag_q <= (flag_q & ~clr) | hit_i;
      irq_q  <= |(flag_q & inten_q);
    end
  end

  always_comb begin
    rd_c = '0;
    if (in_ctrl) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (ctrl_off == ADDR_W'(i)) rd_c = DATA_W'(ctrl_q[i]);
    end else begin
      case (addr_i)
        A_IN:    rd_c = DATA_W'(in_val_i);
        A_MASK:  rd_c = DATA_W'(mask_q);
        A_INTEN: rd_c = DATA_W'(inten_q);
        A_FLAGS: rd_c = DATA_W'(flag_q);
        default: rd_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_c;
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  a_r4_mask_clears: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (mask_q == '0))
    else $error("R4 mask not cleared");

  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (inten_q == '0) |=> !irq_q)
    else $error("R12 irq with no enable");

endmodule

// File: rtl/gpio_mp_port.sv
module gpio_mp_port
  import gpio_mp_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_event,
  output logic                irq
);

  logic [NUM_PINS-1:0]              sync_val;
  logic [NUM_PINS-1:0]              in_val;
  logic [NUM_PINS-1:0]              hit;
  logic [NUM_PINS-1:0][SENSE_W-1:0] ctrl;

  gpio_mp_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_in),
    .sync_o  (sync_val)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_mp_sense u_sense (
      .clk       (clk),
      .rst       (rst),
      .sync_i    (sync_val[i]),
      .mode_i    (ctrl[i]),
      .pin_val_o (in_val[i]),
      .hit_o     (hit[i]),
      .evt_o     (pin_event[i])
    );
  end

  gpio_mp_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .we_i     (bus_we),
    .in_val_i (in_val),
    .hit_i    (hit),
    .ctrl_o   (ctrl),
    .rdata_o  (bus_rdata),
    .irq_o    (irq)
  );

endmodule

// File: tb/gpio_mp_port_bench.sv
module gpio_mp_port_bench;

  localparam logic [4:0] A_IN    = 5'd0;
  localparam logic [4:0] A_MASK  = 5'd1;
  localparam logic [4:0] A_INTEN = 5'd2;
  localparam logic [4:0] A_FLAGS = 5'd3;
  localparam logic [4:0] A_CTRL  = 5'd8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_event;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_mp_port u_gpio_mp_port (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_event (pin_event),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // change one pin, then check the event three edges later and its end
  task automatic probe(input int idx, input logic val, input logic [7:0] exp, input string req);
    @(negedge clk);
    pin_in[idx] = val;
    repeat (3) @(negedge clk);
    check(req, pin_event, exp);
    @(negedge clk);
    check(req, pin_event, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", irq, 0);
    check("R1 event", pin_event, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(A_MASK, d);  check("R1 mask", d, 0);
    rd(A_INTEN, d); check("R1 inten", d, 0);
    rd(A_FLAGS, d); check("R1 flags", d, 0);
    rd(A_CTRL + 5'd3, d); check("R1 ctrl3", d, 0);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk);
    pin_in = 8'hA5; bus_addr = A_IN;
    repeat (2) @(negedge clk);
    check("R2 input not yet visible", bus_rdata, 8'h00);
    @(negedge clk);
    check("R2 input visible", bus_rdata, 8'hA5);
    check("R7 both-edge events", pin_event, 8'hA5);
    @(negedge clk);
    check("R7 events one cycle", pin_event, 8'h00);
    rd(A_FLAGS, d); check("R7 flags", d, 8'hA5);
    wr(A_FLAGS, 8'h05);
    rd(A_FLAGS, d); check("R11 selective clear", d, 8'hA0);
    wr(A_FLAGS, 8'h00);
    rd(A_FLAGS, d); check("R11 zero write keeps", d, 8'hA0);
    wr(A_FLAGS, 8'hFF);
    rd(A_FLAGS, d); check("R11 full clear", d, 8'h00);
    @(negedge clk);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    wr(A_FLAGS, 8'hFF);
  endtask

  task automatic t_broadcast;
    logic [7:0] d;
    wr(A_MASK, 8'h0C);
    rd(A_MASK, d); check("R4 mask loaded", d, 8'h0C);
    wr(A_CTRL + 5'd0, 8'h01);
    rd(A_MASK, d); check("R4 mask self-clear", d, 8'h00);
    rd(A_CTRL + 5'd0, d); check("R3 addressed pin", d, 8'h01);
    rd(A_CTRL + 5'd2, d); check("R3 masked pin2", d, 8'h01);
    rd(A_CTRL + 5'd3, d); check("R3 masked pin3", d, 8'h01);
    rd(A_CTRL + 5'd1, d); check("R3 unmasked pin1", d, 8'h00);
    wr(A_CTRL + 5'd1, 8'h02);
    rd(A_CTRL + 5'd1, d); check("R3 single write", d, 8'h02);
    rd(A_CTRL + 5'd2, d); check("R3 no stale broadcast", d, 8'h01);
    wr(A_CTRL + 5'd4, 8'hF8);
    rd(A_CTRL + 5'd4, d); check("R3 upper bits zero", d, 8'h00);
  endtask

  task automatic t_rise;
    logic [7:0] d;
    probe(2, 1'b1, 8'h04, "R5 rise event");
    rd(A_FLAGS, d); check("R5 rise flag", d, 8'h04);
    wr(A_FLAGS, 8'hFF);
    probe(2, 1'b0, 8'h00, "R5 fall ignored");
    rd(A_FLAGS, d); check("R5 no flag on fall", d, 8'h00);
  endtask

  task automatic t_fall;
    logic [7:0] d;
    probe(1, 1'b1, 8'h00, "R6 rise ignored");
    rd(A_FLAGS, d); check("R6 no flag on rise", d, 8'h00);
    probe(1, 1'b0, 8'h02, "R6 fall event");
    rd(A_FLAGS, d); check("R6 fall flag", d, 8'h02);
    wr(A_FLAGS, 8'hFF);
  endtask

  task automatic t_both;
    probe(4, 1'b1, 8'h10, "R7 rise in both mode");
    probe(4, 1'b0, 8'h10, "R7 fall in both mode");
    wr(A_FLAGS, 8'hFF);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    wr(A_CTRL + 5'd6, 8'h07);
    rd(A_CTRL + 5'd6, d); check("R9 off code stored", d, 8'h07);
    probe(6, 1'b1, 8'h00, "R9 no event");
    rd(A_IN, d); check("R9 input reads zero", d, 8'h00);
    rd(A_FLAGS, d); check("R9 no flag", d, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(A_CTRL + 5'd7, 8'h05);
    rd(A_CTRL + 5'd7, d); check("R10 code 5 stored", d, 8'h05);
    probe(7, 1'b1, 8'h00, "R10 no event on rise");
    rd(A_IN, d); check("R10 input still read", d, 8'h80);
    wr(A_CTRL + 5'd7, 8'h06);
    rd(A_CTRL + 5'd7, d); check("R10 code 6 stored", d, 8'h06);
    probe(7, 1'b0, 8'h00, "R10 no event on fall");
    rd(A_FLAGS, d); check("R10 no flag", d, 8'h00);
  endtask

  task automatic t_irq;
    wr(A_INTEN, 8'h04);
    @(negedge clk);
    pin_in[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 irq not yet", irq, 0);
    @(negedge clk);
    check("R12 irq raised", irq, 1);
    wr(A_FLAGS, 8'h04);
    check("R12 irq lags clear", irq, 1);
    @(negedge clk);
    check("R12 irq dropped", irq, 0);
    probe(4, 1'b1, 8'h10, "R7 event on non-enabled pin");
    repeat (2) @(negedge clk);
    check("R12 non-enabled flag no irq", irq, 0);
    wr(A_FLAGS, 8'hFF);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(A_CTRL + 5'd5, 8'h03);
    repeat (3) @(negedge clk);
    wr(A_FLAGS, 8'hFF);
    rd(A_FLAGS, d); check("R8 low keeps flag", d, 8'h20);
    check("R8 no event while low", pin_event, 8'h00);
    @(negedge clk);
    pin_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 event while high", pin_event, 8'h20);
    repeat (3) @(negedge clk);
    check("R8 event persists", pin_event, 8'h20);
    wr(A_FLAGS, 8'h20);
    rd(A_FLAGS, d); check("R8 flag clears when high", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sync();
    t_broadcast();
    t_rise();
    t_fall();
    t_both();
    t_disable();
    t_reserved();
    t_irq();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule